// File: doc/BRIEF.md
# Multiprocessor-Mode UART Transceiver

This block is a full-duplex asynchronous serial port that carries a ninth bit in every frame. The ninth bit, sent after the eight data bits, tells listeners whether the frame holds a station address (ninth bit 1) or a payload byte (ninth bit 0). Several stations can then share one line. Each station ignores payload traffic until an address frame arrives, and its software decides whether the following payload is meant for it.

On the transmit side the host writes a byte together with the ninth-bit value it wants. The byte waits in a holding register until the shifter is free. The empty flag tells the host when the holding register can take the next byte. Frames run back to back with no idle gap while the host keeps up. When the last stop bit ends with nothing waiting, the end flag rises and the line rests high.

On the receive side the host can arm an address filter. While the filter is armed, frames whose ninth bit is 0 are dropped with no trace. The first frame whose ninth bit is 1 is stored, and that frame also disarms the filter. Accepted frames set a full flag. A low stop bit sets a framing-error flag, and a frame that finishes while the full flag is still set raises an overrun flag. A free-running oversampling tick at sixteen times the bit rate comes in from outside.

Transmit state machine: `TX_IDLE` goes to `TX_START` when a byte is pending. `TX_START` goes to `TX_DATA` at the end of the bit. `TX_DATA` goes to `TX_MPB` after the eighth data bit. `TX_MPB` goes to `TX_STOP` at the end of the bit. `TX_STOP` goes to `TX_START` if a byte is pending and to `TX_IDLE` if not.

Receive state machine: `RX_IDLE` goes to `RX_START` on a low line at a tick. At the half-bit check, `RX_START` goes back to `RX_IDLE` if the line is high and to `RX_DATA` if it is low. `RX_DATA` goes to `RX_MPB` after eight samples. `RX_MPB` goes to `RX_STOP` once the ninth bit is taken. `RX_STOP` goes to `RX_IDLE` on a high stop bit and to `RX_MARK` on a low one. `RX_MARK` goes to `RX_IDLE` once the line is high again.

Top module: `mpx_uart`

## Requirements
- R1: Each transmitted frame has these bits, in this time order: one low start bit, the 8 data bits with bit 0 first, the ninth bit equal to `tx_id` as sampled with that byte's write, and one high stop bit. Every bit lasts 16 `os_tick` pulses. `txd` is high whenever `tx_end` is set.
- R2: A write (`tx_wr` while `tx_empty` is 1) clears `tx_empty` in the next cycle. `tx_empty` is set again one cycle later, when the byte moves to the shifter, and `txd` goes low in that same cycle. A write while `tx_empty` is 0 is ignored. `irq_txe` follows `tx_empty`.
- R3: A byte written while a frame is in flight starts directly after that frame's stop bit, with no idle time between the two frames.
- R4: A write clears `tx_end` in the next cycle. `tx_end` sets when a stop bit ends with no byte pending. `irq_tend` follows `tx_end`.
- R5: When a frame is accepted with `rx_full` clear, `rx_data` and `rx_mpb` are loaded and `rx_full` (and `irq_rxf`) is set.
- R6: While `mp_filt` is 1, a received frame whose ninth bit is 0 leaves `rx_full`, `rx_data`, `rx_mpb` and `mp_filt` unchanged.
- R7: While `mp_filt` is 1, a received frame whose ninth bit is 1 is accepted as in R5 and clears `mp_filt`. A `mp_filt_set` pulse sets `mp_filt`.
- R8: A frame accepted while `rx_full` is set and no `rx_clr` is given sets `rx_overrun`. `rx_data` and `rx_mpb` keep the earlier frame.
- R9: An accepted frame whose stop bit samples low sets `rx_frame_err`.
- R10: An `rx_clr` pulse clears `rx_full`, `rx_overrun` and `rx_frame_err` in the next cycle, unless a frame completes in the same cycle.
- R11: After reset `txd`=1, `tx_empty`=1, `tx_end`=1, `rx_full`=0, `rx_overrun`=0, `rx_frame_err`=0 and `mp_filt`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| tx_wr | input | 1 | Transmit byte write strobe |
| tx_data | input | 8 | Byte to transmit |
| tx_id | input | 1 | Ninth bit for the written byte (1 = address) |
| txd | output | 1 | Serial transmit line |
| tx_empty | output | 1 | Holding register can take a byte |
| tx_end | output | 1 | Transmitter idle with nothing pending |
| irq_txe | output | 1 | Transmit-empty interrupt request |
| irq_tend | output | 1 | Transmit-end interrupt request |
| rxd | input | 1 | Serial receive line |
| rx_clr | input | 1 | Clears receive full and error flags |
| mp_filt_set | input | 1 | Arms the address filter |
| rx_data | output | 8 | Last accepted byte |
| rx_mpb | output | 1 | Ninth bit of the last accepted byte |
| rx_full | output | 1 | Received byte waiting |
| rx_overrun | output | 1 | Frame arrived while full |
| rx_frame_err | output | 1 | Low stop bit seen |
| mp_filt | output | 1 | Address filter armed |
| irq_rxf | output | 1 | Receive-full interrupt request |

## Verification
Host-side transmit flags are due one cycle after the write edge (`tx_empty` low, `tx_end` low), and the shifter load follows one cycle later (`tx_empty` high, `txd` low). The bench samples each of these on the falling clock edge directly after the rising edge that produced it. Serial results take a whole frame of 11 bits at 64 clocks each. The bench therefore detects the start edge, samples each bit at its centre, and reads the receive flags only after a fixed margin past the last stop-bit centre, so that synchroniser delay and tick phase cannot shift a result into the wrong window.

// File: rtl/mpx_uart_pkg.sv
package mpx_uart_pkg;
    localparam int UART_DW  = 8;
    localparam int UART_OSR = 16;

    typedef enum logic [2:0] {
        TX_IDLE, TX_START, TX_DATA, TX_MPB, TX_STOP
    } tx_state_e;

    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_DATA, RX_MPB, RX_STOP, RX_MARK
    } rx_state_e;
endpackage

// File: rtl/mpx_uart_tx.sv
module mpx_uart_tx
    import mpx_uart_pkg::*;
#(
    parameter int DW  = UART_DW,
    parameter int OSR = UART_OSR
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          os_tick,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic          wid,
    output logic          txd,
    output logic          empty,
    output logic          tend
);
    localparam int CW = $clog2(OSR);
    localparam int IW = (DW > 1) ? $clog2(DW) : 1;

    tx_state_e     st, st_nx;
    logic [DW-1:0] hold_q, sh_q;
    logic          hold_id, sh_id;
    logic [CW-1:0] sub_q;
    logic [IW-1:0] idx_q;
    logic          bit_end, load, accept_wr;

    assign bit_end   = os_tick && (sub_q == CW'(OSR - 1));
    assign accept_wr = wr && empty;
    assign load      = !empty && ((st == TX_IDLE) || ((st == TX_STOP) && bit_end));

    // next state
    always_comb begin
        st_nx = st;
        unique case (st)
            TX_IDLE:  if (load) st_nx = TX_START;
            TX_START: if (bit_end) st_nx = TX_DATA;
            TX_DATA:  if (bit_end && (idx_q == IW'(DW - 1))) st_nx = TX_MPB;
            TX_MPB:   if (bit_end) st_nx = TX_STOP;
            TX_STOP:  if (bit_end) st_nx = load ? TX_START : TX_IDLE;
            default:  st_nx = TX_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= TX_IDLE;
        else        st <= st_nx;
    end

    // line output
    always_comb begin
        unique case (st)
            TX_IDLE:  txd = 1'b1;
            TX_START: txd = 1'b0;
            TX_DATA:  txd = sh_q[0];
            TX_MPB:   txd = sh_id;
            TX_STOP:  txd = 1'b1;
            default:  txd = 1'b1;
        endcase
    end

    // datapath and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q  <= '0;
            hold_id <= 1'b0;
            sh_q    <= '0;
            sh_id   <= 1'b0;
            sub_q   <= '0;
            idx_q   <= '0;
            empty   <= 1'b1;
            tend    <= 1'b1;
        end else begin
            if (load || bit_end)  sub_q <= '0;
            else if (os_tick)     sub_q <= sub_q + 1'b1;

            if (load)                            idx_q <= '0;
            else if ((st == TX_DATA) && bit_end) idx_q <= idx_q + 1'b1;

            if (load) begin
                sh_q  <= hold_q;
                sh_id <= hold_id;
            end else if ((st == TX_DATA) && bit_end) begin
                sh_q <= sh_q >> 1;
            end

            if (accept_wr) begin
                hold_q  <= wdata;
                hold_id <= wid;
                empty   <= 1'b0;
            end else if (load) begin
                empty <= 1'b1;
            end

            if (accept_wr)                                 tend <= 1'b0;
            else if ((st == TX_STOP) && bit_end && !load)  tend <= 1'b1;
        end
    end
endmodule

// File: rtl/mpx_uart_rx.sv
module mpx_uart_rx
    import mpx_uart_pkg::*;
#(
    parameter int DW  = UART_DW,
    parameter int OSR = UART_OSR
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          os_tick,
    input  logic          rxd,
    output logic          done,
    output logic [DW-1:0] byte_o,
    output logic          mpb_o,
    output logic          stop_o
);
    localparam int CW = $clog2(OSR);
    localparam int IW = (DW > 1) ? $clog2(DW) : 1;

    rx_state_e     st, st_nx;
    logic [1:0]    sync_q;
    logic          rxs, mid;
    logic [CW-1:0] cnt_q;
    logic [IW-1:0] idx_q;
    logic [DW-1:0] sh_q;
    logic          mpb_q;

    assign rxs = sync_q[1];
    assign mid = os_tick && (cnt_q == ((st == RX_START) ? CW'(OSR / 2 - 1) : CW'(OSR - 1)));

    // next state
    always_comb begin
        st_nx = st;
        unique case (st)
            RX_IDLE:  if (os_tick && !rxs) st_nx = RX_START;
            RX_START: if (mid) st_nx = rxs ? RX_IDLE : RX_DATA;
            RX_DATA:  if (mid && (idx_q == IW'(DW - 1))) st_nx = RX_MPB;
            RX_MPB:   if (mid) st_nx = RX_STOP;
            RX_STOP:  if (mid) st_nx = rxs ? RX_IDLE : RX_MARK;
            RX_MARK:  if (rxs) st_nx = RX_IDLE;
            default:  st_nx = RX_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= RX_IDLE;
        else        st <= st_nx;
    end

    // outputs toward the host side
    always_comb begin
        done   = (st == RX_STOP) && mid;
        byte_o = sh_q;
        mpb_o  = mpb_q;
        stop_o = rxs;
    end

    // sampling datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= 2'b11;
            cnt_q  <= '0;
            idx_q  <= '0;
            sh_q   <= '0;
            mpb_q  <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], rxd};

            if ((st == RX_IDLE) || (st == RX_MARK) || mid) cnt_q <= '0;
            else if (os_tick)                              cnt_q <= cnt_q + 1'b1;

            if (st == RX_IDLE) idx_q <= '0;
            else if ((st == RX_DATA) && mid) begin
                idx_q <= idx_q + 1'b1;
                sh_q  <= {rxs, sh_q[DW-1:1]};
            end

            if ((st == RX_MPB) && mid) mpb_q <= rxs;
        end
    end
endmodule

// File: rtl/mpx_uart_rxhost.sv
module mpx_uart_rxhost #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          done,
    input  logic [DW-1:0] byte_i,
    input  logic          mpb_i,
    input  logic          stop_i,
    input  logic          clr,
    input  logic          filt_set,
    output logic [DW-1:0] data_q,
    output logic          mpb_q,
    output logic          full_q,
    output logic          ovr_q,
    output logic          ferr_q,
    output logic          filt_q
);
    logic accept, busy;

    assign accept = done && (!filt_q || mpb_i);
    assign busy   = full_q && !clr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            mpb_q  <= 1'b0;
            full_q <= 1'b0;
            ovr_q  <= 1'b0;
            ferr_q <= 1'b0;
            filt_q <= 1'b0;
        end else begin
            if (filt_set)              filt_q <= 1'b1;
            else if (accept && filt_q) filt_q <= 1'b0;

            if (accept && busy) begin
                ovr_q  <= 1'b1;
                ferr_q <= ferr_q | !stop_i;
            end else if (accept) begin
                data_q <= byte_i;
                mpb_q  <= mpb_i;
                full_q <= 1'b1;
                ovr_q  <= 1'b0;
                ferr_q <= !stop_i;
            end else if (clr) begin
                full_q <= 1'b0;
                ovr_q  <= 1'b0;
                ferr_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/mpx_uart.sv
module mpx_uart
    import mpx_uart_pkg::*;
#(
    parameter int DW  = UART_DW,
    parameter int OSR = UART_OSR
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          os_tick,
    input  logic          tx_wr,
    input  logic [DW-1:0] tx_data,
    input  logic          tx_id,
    output logic          txd,
    output logic          tx_empty,
    output logic          tx_end,
    output logic          irq_txe,
    output logic          irq_tend,
    input  logic          rxd,
    input  logic          rx_clr,
    input  logic          mp_filt_set,
    output logic [DW-1:0] rx_data,
    output logic          rx_mpb,
    output logic          rx_full,
    output logic          rx_overrun,
    output logic          rx_frame_err,
    output logic          mp_filt,
    output logic          irq_rxf
);
    logic          rx_done;
    logic [DW-1:0] rx_byte;
    logic          rx_bit9;
    logic          rx_stop;

    mpx_uart_tx #(.DW(DW), .OSR(OSR)) u_tx (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick),
        .wr(tx_wr), .wdata(tx_data), .wid(tx_id),
        .txd(txd), .empty(tx_empty), .tend(tx_end)
    );

    mpx_uart_rx #(.DW(DW), .OSR(OSR)) u_rx (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
        .done(rx_done), .byte_o(rx_byte), .mpb_o(rx_bit9), .stop_o(rx_stop)
    );

    mpx_uart_rxhost #(.DW(DW)) u_host (
        .clk(clk), .rst_n(rst_n), .done(rx_done), .byte_i(rx_byte),
        .mpb_i(rx_bit9), .stop_i(rx_stop), .clr(rx_clr), .filt_set(mp_filt_set),
        .data_q(rx_data), .mpb_q(rx_mpb), .full_q(rx_full),
        .ovr_q(rx_overrun), .ferr_q(rx_frame_err), .filt_q(mp_filt)
    );

    assign irq_txe  = tx_empty;
    assign irq_tend = tx_end;
    assign irq_rxf  = rx_full;
endmodule

// File: rtl/mpx_uart_chk.sv
module mpx_uart_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tx_wr,
    input logic          tx_empty,
    input logic          tx_end,
    input logic          txd,
    input logic          rx_clr,
    input logic          rx_done,
    input logic          rx_full,
    input logic          rx_overrun,
    input logic          rx_frame_err,
    input logic          mp_filt,
    input logic [DW-1:0] rx_data
);
    p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tx_end |-> txd);

    p_empty_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr && tx_empty) |=> !tx_empty);

    p_end_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr && tx_empty) |=> !tx_end);

    p_filter_drop_only_on_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mp_filt) |-> rx_full);

    p_hold_while_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && !rx_clr) |=> (rx_full && $stable(rx_data)));

    p_frame_err_with_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_frame_err) |-> rx_full);

    p_clear_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_clr && !rx_done) |=> (!rx_full && !rx_overrun && !rx_frame_err));
endmodule

bind mpx_uart mpx_uart_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .tx_wr(tx_wr), .tx_empty(tx_empty),
    .tx_end(tx_end), .txd(txd), .rx_clr(rx_clr), .rx_done(rx_done),
    .rx_full(rx_full), .rx_overrun(rx_overrun), .rx_frame_err(rx_frame_err),
    .mp_filt(mp_filt), .rx_data(rx_data)
);

// File: tb/test_mpx_uart.sv
module test_mpx_uart;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] tdiv = 2'd0;
    logic       os_tick;
    logic       tx_wr = 1'b0, tx_id = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       txd, tx_empty, tx_end, irq_txe, irq_tend;
    logic       rxd, rxd_drv = 1'b1, loop = 1'b0;
    logic       rx_clr = 1'b0, mp_filt_set = 1'b0;
    logic [7:0] rx_data;
    logic       rx_mpb, rx_full, rx_overrun, rx_frame_err, mp_filt, irq_rxf;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;
    always @(posedge clk) tdiv <= tdiv + 2'd1;
    assign os_tick = (tdiv == 2'd3);
    assign rxd = loop ? txd : rxd_drv;

    mpx_uart i_mpx_uart (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick),
        .tx_wr(tx_wr), .tx_data(tx_data), .tx_id(tx_id),
        .txd(txd), .tx_empty(tx_empty), .tx_end(tx_end),
        .irq_txe(irq_txe), .irq_tend(irq_tend),
        .rxd(rxd), .rx_clr(rx_clr), .mp_filt_set(mp_filt_set),
        .rx_data(rx_data), .rx_mpb(rx_mpb), .rx_full(rx_full),
        .rx_overrun(rx_overrun), .rx_frame_err(rx_frame_err),
        .mp_filt(mp_filt), .irq_rxf(irq_rxf)
    );

    // {filt_set, id, data, exp_full, exp_data, exp_mpb, exp_filt}
    localparam logic [20:0] VEC [0:5] = '{
        {1'b0, 1'b0, 8'h5A, 1'b1, 8'h5A, 1'b0, 1'b0},  // R5 data frame
        {1'b0, 1'b1, 8'hA5, 1'b1, 8'hA5, 1'b1, 1'b0},  // R5 address frame
        {1'b1, 1'b0, 8'h3C, 1'b0, 8'hA5, 1'b1, 1'b1},  // R6 dropped
        {1'b0, 1'b1, 8'h81, 1'b1, 8'h81, 1'b1, 1'b0},  // R7 address disarms
        {1'b0, 1'b0, 8'hFF, 1'b1, 8'hFF, 1'b0, 1'b0},  // R5 all ones
        {1'b0, 1'b0, 8'h00, 1'b1, 8'h00, 1'b0, 1'b0}   // R5 all zeros
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tx_write(input logic [7:0] d, input logic id);
        @(negedge clk);
        tx_data = d; tx_id = id; tx_wr = 1'b1;
        @(negedge clk);
        tx_wr = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk); rx_clr = 1'b1;
        @(negedge clk); rx_clr = 1'b0;
    endtask

    task automatic pulse_filt();
        @(negedge clk); mp_filt_set = 1'b1;
        @(negedge clk); mp_filt_set = 1'b0;
    endtask

    task automatic grab(input int n, output logic [31:0] bits);
        bits = '0;
        do @(negedge clk); while (txd !== 1'b0);
        repeat (32) @(negedge clk);
        for (int k = 0; k < n; k++) begin
            bits[k] = txd;
            repeat (64) @(negedge clk);
        end
    endtask

    task automatic send_raw(input logic [7:0] d, input logic m, input logic s);
        logic [10:0] f;
        f = {s, m, d, 1'b0};
        for (int k = 0; k < 11; k++) begin
            rxd_drv = f[k];
            repeat (64) @(negedge clk);
        end
        rxd_drv = 1'b1;
        repeat (100) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] bits;
        logic [20:0] e;
        repeat (4) @(negedge clk);
        // R11 reset state
        check("R11 txd", txd, 1);
        check("R11 tx_empty", tx_empty, 1);
        check("R11 tx_end", tx_end, 1);
        check("R11 rx_full", rx_full, 0);
        check("R11 rx_overrun", rx_overrun, 0);
        check("R11 rx_frame_err", rx_frame_err, 0);
        check("R11 mp_filt", mp_filt, 0);
        rst_n = 1'b1;
        repeat (8) @(negedge clk);

        // R2/R4 flag timing after one write
        tx_write(8'hC3, 1'b0);
        check("R2 empty clears", tx_empty, 0);
        check("R2 irq_txe", irq_txe, 0);
        check("R4 end clears", tx_end, 0);
        @(negedge clk);
        check("R2 empty sets on load", tx_empty, 1);
        check("R1 start bit low", txd, 0);
        repeat (800) @(negedge clk);
        check("R4 end after frame", tx_end, 1);
        check("R4 irq_tend", irq_tend, 1);
        check("R1 idle high", txd, 1);

        // R2 write while not empty is ignored
        fork
            grab(11, bits);
            begin
                @(negedge clk);
                tx_data = 8'h12; tx_id = 1'b0; tx_wr = 1'b1;
                @(negedge clk);
                tx_data = 8'h34; tx_id = 1'b1;
                @(negedge clk);
                tx_wr = 1'b0;
            end
        join
        check("R2 second write ignored", {21'd0, bits[10:0]}, {21'd0, 1'b1, 1'b0, 8'h12, 1'b0});
        repeat (100) @(negedge clk);

        // R3 back to back
        fork
            grab(22, bits);
            begin
                tx_write(8'h96, 1'b0);
                do @(negedge clk); while (!tx_empty);
                tx_write(8'h4B, 1'b1);
            end
        join
        check("R3 two frames no gap", {10'd0, bits[21:0]},
              {10'd0, 1'b1, 1'b1, 8'h4B, 1'b0, 1'b1, 1'b0, 8'h96, 1'b0});
        repeat (200) @(negedge clk);
        check("R4 end after burst", tx_end, 1);

        // loopback vector walk: R1 R5 R6 R7
        loop = 1'b1;
        for (int v = 0; v < 6; v++) begin
            e = VEC[v];
            if (e[20]) pulse_filt();
            fork
                grab(11, bits);
                tx_write(e[18:11], e[19]);
            join
            repeat (100) @(negedge clk);
            check($sformatf("R1 frame v%0d", v), {21'd0, bits[10:0]}, {21'd0, 1'b1, e[19], e[18:11], 1'b0});
            check($sformatf("R5/R6/R7 full v%0d", v), rx_full, e[10]);
            check($sformatf("R5/R6 data v%0d", v), rx_data, e[9:2]);
            check($sformatf("R5/R6 mpb v%0d", v), rx_mpb, e[1]);
            check($sformatf("R7 filt v%0d", v), mp_filt, e[0]);
            check($sformatf("R5 irq_rxf v%0d", v), irq_rxf, e[10]);
            if (rx_full) pulse_clr();
        end

        // R8 overrun keeps the first byte
        fork grab(11, bits); tx_write(8'h11, 1'b0); join
        repeat (100) @(negedge clk);
        fork grab(11, bits); tx_write(8'h22, 1'b1); join
        repeat (100) @(negedge clk);
        check("R8 overrun set", rx_overrun, 1);
        check("R8 data kept", rx_data, 8'h11);
        check("R8 mpb kept", rx_mpb, 0);
        check("R8 full held", rx_full, 1);
        pulse_clr();
        check("R10 full cleared", rx_full, 0);
        check("R10 overrun cleared", rx_overrun, 0);

        // R9 framing error from a low stop bit
        loop = 1'b0;
        send_raw(8'h6E, 1'b0, 1'b0);
        check("R9 frame error", rx_frame_err, 1);
        check("R9 data stored", rx_data, 8'h6E);
        check("R9 full", rx_full, 1);
        pulse_clr();
        check("R10 frame error cleared", rx_frame_err, 0);
        send_raw(8'h93, 1'b1, 1'b1);
        check("R9 good stop no error", rx_frame_err, 0);
        check("R5 raw data", rx_data, 8'h93);
        check("R5 raw mpb", rx_mpb, 1);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule